// File: doc/BRIEF.md
# Self-Timed Fall-Through FIFO

This block is a first-in first-out buffer built as a chain of storage stages that each hold one word and a valid bit. A word written at the input end moves forward by itself, one stage per clock, whenever the stage ahead of it is empty. It settles behind the last occupied slot or at the output stage. When a word is read from the output stage, the freed slot travels back toward the input one stage per clock. Both the forward ripple and the backward bubble are visible cycle by cycle.

The write side is a strobe-and-flag pair. `in_ready` high means the input stage is empty. While `in_ready` is high, raising `shift_in` captures `din`. The producer must then drop `shift_in` before the captured word may leave the input stage or a second word can be written. The read side mirrors this. `out_ready` high means a word is presented on `q`. Raising `shift_out` consumes that word. The next word enters the output stage only after `shift_out` returns low. Back-pressure works as follows: a producer holding `shift_in` high while `in_ready` is low writes nothing until a slot reaches the input stage, and a consumer holding `shift_out` high blocks further advance into the output stage. Because of this, two instances can be chained directly: `out_ready` of the first drives `shift_in` of the second, and `in_ready` of the second drives `shift_out` of the first.

An active-low asynchronous reset empties every stage. An output enable gates the data outputs.

Top module: `ripple_fifo`

## Requirements
- R1: While `mr_n` is low, `in_ready` is 1, `out_ready` is 0 and `q` is all zeros.
- R2: If `shift_in` and `in_ready` are both high at a rising edge, `din` is captured and `in_ready` is low after that edge. Only one word is written per high period of `shift_in`, however long it lasts.
- R3: For a word written into an empty FIFO whose `shift_in` is released right after capture, `out_ready` rises DEPTH-1 clock edges after the capture edge, with that word on `q`.
- R4: If `shift_out` and `out_ready` are both high at a rising edge, the presented word is consumed and `out_ready` is low after that edge. While `shift_out` stays high, no further word enters the output stage. The next word is presented one edge after `shift_out` is seen low.
- R5: Words leave in the order they were written, including when writes and reads overlap with irregular gaps.
- R6: The FIFO holds exactly DEPTH (64) words. When it is full, `in_ready` stays low and a `shift_in` pulse writes nothing.
- R7: When the FIFO is full and `shift_in` is held high, a read frees a slot that reaches the input stage DEPTH-1 edges after the read edge. `in_ready` is then high for one cycle, the pending `din` is captured at the following edge, and `in_ready` drops again.
- R8: When `oe` is low, `q` reads all zeros and `q_en` is 0, with `out_ready` unaffected. When `oe` is high, `q` shows the output stage and `q_en` is 1.
- R9: Pulling `mr_n` low at any time discards all stored words. After its release, no word is presented until a new write.
- R10: A presented word stays on `q`, with `out_ready` high, until it is read.
- R11: Two instances chained serially act as a single FIFO of twice the depth that preserves order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mr_n | input | 1 | Asynchronous active-low reset; empties all stages |
| shift_in | input | 1 | Write strobe |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | Input stage empty, write possible |
| shift_out | input | 1 | Read strobe |
| out_ready | output | 1 | Output stage holds a valid word |
| oe | input | 1 | Output enable for `q` |
| q | output | WIDTH | Output stage word, zero when `oe` is low |
| q_en | output | 1 | Drive-enable indication for `q` |

## Verification
Every cycle, the assertions check the following: the flags are in their reset values, each flag drops right after its own handshake, and a presented word stays in place and stays stable until it is read. Only the bench scenarios can show the properties that depend on how a word moves along the chain. These are the exact DEPTH-1 ripple and bubble latencies, first-in first-out order, the capacity limit and the ignored write when full, the deferred capture under a held `shift_in`, the flush on reset, and the doubled capacity of a serial cascade.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned DEPTH_DEF = 64;
  localparam int unsigned WIDTH_DEF = 4;

  // Tracks whether the current high period of a strobe has already moved a word.
  typedef enum logic {
    STROBE_FREE  = 1'b0,
    STROBE_SPENT = 1'b1
  } strobe_state_e;
endpackage

// File: rtl/ft_strobe_guard.sv
module ft_strobe_guard
  import ripple_fifo_pkg::*;
(
  input  logic clk,
  input  logic mr_n,
  input  logic strobe,
  input  logic fire,
  output logic block
);
  strobe_state_e st;

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n)        st <= STROBE_FREE;
    else if (fire)    st <= STROBE_SPENT;
    else if (!strobe) st <= STROBE_FREE;
  end

  // Movement next to the strobe's stage is held off while the spent strobe stays high.
  assign block = (st == STROBE_SPENT) && strobe;
endmodule

// File: rtl/ft_stage.sv
module ft_stage #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             load,
  input  logic             leave,
  input  logic [WIDTH-1:0] d_in,
  output logic             valid,
  output logic [WIDTH-1:0] d_out
);
  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      valid <= 1'b0;
      d_out <= '0;
    end else if (load) begin
      valid <= 1'b1;
      d_out <= d_in;
    end else if (leave) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEPTH_DEF,
  parameter int unsigned WIDTH = WIDTH_DEF
) (
  input  logic             clk,
  input  logic             mr_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  input  logic             oe,
  output logic [WIDTH-1:0] q,
  output logic             q_en
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] v;
  logic [DEPTH-1:0] load;
  logic [DEPTH-1:0] leave;
  logic [LAST-1:0]  mv;
  logic [WIDTH-1:0] dat [DEPTH];
  logic             wr, rd, in_blk, out_blk;

  assign wr = shift_in & ~v[0];
  assign rd = shift_out & v[LAST];

  ft_strobe_guard u_in_guard (
    .clk(clk), .mr_n(mr_n), .strobe(shift_in), .fire(wr), .block(in_blk)
  );

  ft_strobe_guard u_out_guard (
    .clk(clk), .mr_n(mr_n), .strobe(shift_out), .fire(rd), .block(out_blk)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k < LAST) begin : g_move
      localparam logic FIRST     = (k == 0);
      localparam logic INTO_LAST = (k == LAST - 1);
      assign mv[k]    = v[k] & ~v[k+1] & ~(FIRST & in_blk) & ~(INTO_LAST & out_blk);
      assign leave[k] = mv[k];
    end else begin : g_read
      assign leave[k] = rd;
    end

    if (k == 0) begin : g_head
      assign load[k] = wr;
      ft_stage #(.WIDTH(WIDTH)) u_st (
        .clk(clk), .mr_n(mr_n), .load(load[k]), .leave(leave[k]),
        .d_in(din), .valid(v[k]), .d_out(dat[k])
      );
    end else begin : g_body
      assign load[k] = mv[k-1];
      ft_stage #(.WIDTH(WIDTH)) u_st (
        .clk(clk), .mr_n(mr_n), .load(load[k]), .leave(leave[k]),
        .d_in(dat[k-1]), .valid(v[k]), .d_out(dat[k])
      );
    end
  end

  assign in_ready  = ~v[0];
  assign out_ready = v[LAST];
  assign q         = oe ? dat[LAST] : '0;
  assign q_en      = oe;
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             mr_n,
  input logic             shift_in,
  input logic             in_ready,
  input logic             shift_out,
  input logic             out_ready,
  input logic             oe,
  input logic [WIDTH-1:0] q
);
  p_reset_flags_r1: assert property (@(posedge clk)
    !mr_n |=> (in_ready && !out_ready && q == '0));

  p_dir_drops_r2: assert property (@(posedge clk) disable iff (!mr_n)
    shift_in && in_ready |=> !in_ready);

  p_dor_drops_r4: assert property (@(posedge clk) disable iff (!mr_n)
    shift_out && out_ready |=> !out_ready);

  p_word_held_r10: assert property (@(posedge clk) disable iff (!mr_n)
    out_ready && !shift_out |=> out_ready);

  p_q_stable_r10: assert property (@(posedge clk) disable iff (!mr_n)
    out_ready && !shift_out && oe |=> (!oe || $stable(q)));
endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .mr_n(mr_n), .shift_in(shift_in), .in_ready(in_ready),
  .shift_out(shift_out), .out_ready(out_ready), .oe(oe), .q(q)
);

// File: tb/sim_ripple_fifo.sv
module sim_ripple_fifo;
  localparam int W = 4;
  localparam int D = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mr_n = 1'b0, si = 1'b0, so_mon = 1'b0, so_man = 1'b0, oe = 1'b1;
  logic [W-1:0] din = '0;
  logic in_ready, out_ready, q_en, shift_out;
  logic [W-1:0] q;
  assign shift_out = so_mon | so_man;

  ripple_fifo #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .mr_n(mr_n), .shift_in(si), .din(din), .in_ready(in_ready),
    .shift_out(shift_out), .out_ready(out_ready), .oe(oe), .q(q), .q_en(q_en)
  );

  // Serial cascade of two short instances
  logic c_si = 1'b0, c_so = 1'b0;
  logic [W-1:0] c_din = '0;
  logic c1_ir, c1_or, c2_ir, c2_or, c1_qen, c2_qen;
  logic [W-1:0] c1_q, c2_q;

  ripple_fifo #(.DEPTH(4), .WIDTH(W)) u1 (
    .clk(clk), .mr_n(mr_n), .shift_in(c_si), .din(c_din), .in_ready(c1_ir),
    .shift_out(c2_ir), .out_ready(c1_or), .oe(1'b1), .q(c1_q), .q_en(c1_qen)
  );
  ripple_fifo #(.DEPTH(4), .WIDTH(W)) u2 (
    .clk(clk), .mr_n(mr_n), .shift_in(c1_or), .din(c1_q), .in_ready(c2_ir),
    .shift_out(c_so), .out_ready(c2_or), .oe(1'b1), .q(c2_q), .q_en(c2_qen)
  );

  int total = 0, fails = 0;
  logic [W-1:0] exp_q[$];
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    din = d; si = 1'b1; exp_q.push_back(d);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    si = 1'b0;
  endtask

  task automatic drain();
    mon_en = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
  endtask

  // Monitor: reads each presented word and compares with the scoreboard (R5)
  always @(negedge clk) begin
    logic [W-1:0] e;
    if (mon_en && out_ready && !so_mon) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", q, 0);
      else begin
        e = exp_q.pop_front();
        chk(q == e, "R5 order", q, e);
      end
      so_mon <= 1'b1;
    end else begin
      so_mon <= 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] e;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_ready == 1'b0, "R1 out_ready", out_ready, 0);
    chk(q == '0, "R1 q", q, 0);
    mr_n = 1'b1;

    // R3 latency and R2 flag drop
    @(negedge clk);
    din = 4'h3; si = 1'b1; exp_q.push_back(4'h3);
    @(negedge clk);
    chk(!in_ready, "R2 in_ready after capture", in_ready, 0);
    si = 1'b0;
    n = 0;
    while (!out_ready) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == D - 1, "R3 latency", n, D - 1);
    chk(q == 4'h3, "R3 data", q, 3);
    drain();

    // R2 one write per long strobe
    @(negedge clk);
    din = 4'h9; si = 1'b1; exp_q.push_back(4'h9);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!in_ready, "R2 held strobe", in_ready, 0);
    end
    si = 1'b0;
    drain();
    repeat (D + 5) @(negedge clk);
    chk(!out_ready, "R2 single word", out_ready, 0);

    // R5 overlapping traffic
    mon_en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      push(W'(i * 7 + 1));
      repeat (i % 3) @(negedge clk);
    end
    drain();

    // R10, R8, R4
    push(4'hC); push(4'h5);
    repeat (D + 4) @(negedge clk);
    chk(out_ready && q == 4'hC, "R10 presented", q, 4'hC);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_ready && q == 4'hC, "R10 stable", q, 4'hC);
    end
    oe = 1'b0; #1;
    chk(q == '0, "R8 gated q", q, 0);
    chk(q_en == 1'b0, "R8 q_en", q_en, 0);
    chk(out_ready, "R8 flag kept", out_ready, 1);
    oe = 1'b1; #1;
    chk(q == 4'hC && q_en, "R8 enabled", q, 4'hC);
    @(negedge clk);
    so_man = 1'b1;
    void'(exp_q.pop_front());
    @(negedge clk);
    chk(!out_ready, "R4 drop", out_ready, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!out_ready, "R4 blocked while strobe high", out_ready, 0);
    end
    so_man = 1'b0;
    @(negedge clk);
    chk(out_ready && q == 4'h5, "R4 next word", q, 5);
    drain();

    // R9 reset mid-run
    push(4'h1); push(4'h2); push(4'h3);
    repeat (5) @(negedge clk);
    mr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(in_ready && !out_ready && q == '0, "R9 reset flags", {in_ready, out_ready}, 2);
    mr_n = 1'b1;
    exp_q.delete();
    repeat (D + 5) @(negedge clk);
    chk(!out_ready && in_ready, "R9 flushed", out_ready, 0);

    // R6 capacity and R7 bubble-up with held strobe
    for (int i = 0; i < D; i++) push(W'(i * 5 + 2));
    repeat (10) @(negedge clk);
    chk(!in_ready, "R6 full", in_ready, 0);
    chk(out_ready, "R6 output ready", out_ready, 1);
    din = 4'hA; si = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!in_ready, "R6 write ignored when full", in_ready, 0);
    end
    e = exp_q.pop_front();
    chk(q == e, "R7 head word", q, e);
    so_man = 1'b1;
    @(negedge clk);
    so_man = 1'b0;
    n = 0;
    while (!in_ready) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == D - 1, "R7 bubble latency", n, D - 1);
    @(negedge clk);
    chk(!in_ready, "R7 held word captured", in_ready, 0);
    si = 1'b0;
    exp_q.push_back(4'hA);
    drain();
    repeat (D + 5) @(negedge clk);
    chk(!out_ready, "R6 no extra word", out_ready, 0);

    // R11 serial cascade
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      c_din = W'(i + 3); c_si = 1'b1;
      while (!c1_ir) @(negedge clk);
      @(negedge clk);
      c_si = 1'b0;
    end
    repeat (40) @(negedge clk);
    chk(!c1_ir, "R11 capacity", c1_ir, 0);
    chk(c2_or, "R11 output ready", c2_or, 1);
    for (int i = 0; i < 8; i++) begin
      while (!c2_or) @(negedge clk);
      chk(c2_q == W'(i + 3), "R11 order", c2_q, i + 3);
      c_so = 1'b1;
      @(negedge clk);
      c_so = 1'b0;
      @(negedge clk);
    end
    repeat (40) @(negedge clk);
    chk(!c2_or, "R11 empty after drain", c2_or, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule